// File: doc/BRIEF.md
# Flash Program/Erase Operation Sequencer

This block paces program and erase operations on an embedded flash array. Software loads four mode bits into a small control register and then issues a bus write to the array. That write is the trigger. The sequencer decodes the mode, starts a timing generator and counts timing-generator ticks for the length the mode requires. While it counts it holds `busy` high. It then returns the array to plain read mode and pulses `done`.

The timing generator takes one of three free-running source clocks, each sampled in the system clock domain, and divides it by a programmable factor. One operation type, the block write, is a series of element writes. Between elements the sequencer raises `elem_ready`, and software supplies the next element with another array write. The series ends when software clears the write bits, after which a fixed overhead runs.

Two conditions end an operation early. The emergency-exit input stops any operation at once and clears the control register. A stalled source clock is the second: `fail` is set and the operation is aborted.

Top module: `flash_op_seq`

## Requirements
- R1: After reset, `busy`, `elem_ready`, `done` and `fail` are 0, `op_mode` is 0 and `ctl_q` is 0.
- R2: `clk_sel` picks the timing source: 00 selects `src_a`, 01 selects `src_m`, and both 10 and 11 select `src_s`. A source that is not selected has no effect.
- R3: A value N on `clk_div` makes one timing tick from every N+1 rising edges of the selected source, for N from 0 to 63.
- R4: The `ctl_wdata`/`ctl_q` bit order is {block, write, mass, erase} at bits [3:0]. The codes decode as follows:
  - 0001 is segment erase, shown as `op_mode` 1.
  - 0010 is mass erase, shown as `op_mode` 2.
  - 0011 is full erase (main plus information), shown as `op_mode` 3.
  - 0100 is single byte/word write, shown as `op_mode` 4.
  - 1100 is block write, shown as `op_mode` 5.
  - `op_mode` is 0 whenever `busy` is 0.
- R5: Each of the three erase kinds holds `busy` high for 5000 ticks, and a byte/word write holds it high for 33 ticks. In both cases the count starts at the trigger.
- R6: In block write, each element is programmed for 20 ticks with `elem_ready` at 0. After each element `elem_ready` goes to 1 until the next array write. When the write or block bit is found cleared while `elem_ready` is 1, a 15-tick overhead runs and then `busy` falls.
- R7: `arr_we` starts an operation only when `lock` is 0, `busy` is 0 and the mode code is one of the five listed in R4. Any other array write is ignored, and so is an array write during a counted interval.
- R8: `emex` high at a clock edge drops `busy` and `elem_ready` at that edge, clears `ctl_q` to 0, sets `op_mode` to 0 and produces no `done` pulse.
- R9: If the selected source shows no rising edge for 64 system cycles while `busy` is 1, the operation is aborted and `fail` is set. `fail` stays set until the next accepted trigger clears it.
- R10: `done` is a one-cycle pulse, given only when an operation finishes normally, in the cycle in which `busy` has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | 1 | Timing source A (level, sampled) |
| src_m | input | 1 | Timing source M (level, sampled) |
| src_s | input | 1 | Timing source S (level, sampled) |
| clk_sel | input | 2 | Timing source select |
| clk_div | input | 6 | Divide-by-(N+1) factor |
| ctl_we | input | 1 | Write strobe for the mode register |
| ctl_wdata | input | 4 | Mode bits {block, write, mass, erase} |
| ctl_q | output | 4 | Current mode register contents |
| emex | input | 1 | Emergency exit |
| lock | input | 1 | Blocks triggering when 1 |
| arr_we | input | 1 | Bus write to the flash array (trigger / block element) |
| busy | output | 1 | Operation in progress |
| elem_ready | output | 1 | Block write may take the next element |
| done | output | 1 | One-cycle normal-completion pulse |
| fail | output | 1 | Source clock stall abort flag |
| op_mode | output | 3 | Active operation code |

## Verification
The bench toggles the selected source on every falling clock edge, so the source period P is 2 cycles.

A counted interval of K = ticks × (N+1) source edges ends on the K-th rising edge after the trigger edge. The phase of the first edge is not fixed, so the interval lasts from (K-1)·P+1 to K·P cycles. For example, a segment erase with N=0 lasts 9999 or 10000 cycles. The scoreboard accepts exactly that two-cycle window for every busy segment and every block element.

The scoreboard measures each interval from the first falling edge after the trigger at which the segment is active to the first at which it is not. At that same sample it checks how the segment ended (`done`, `elem_ready`, or a silent abort). `op_mode`, `fail` and ignored triggers are sampled on the first falling edge after the edge that captured the stimulus.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int SEL_W = 2;
    localparam int DIV_W = 6;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_SEG   = 3'd1,
        OP_MASS  = 3'd2,
        OP_FULL  = 3'd3,
        OP_BYTE  = 3'd4,
        OP_BLOCK = 3'd5
    } op_e;

    typedef struct packed {
        logic blk;
        logic wrt;
        logic meras;
        logic erase;
    } ctl_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RUN,
        S_ELEM,
        S_GAP,
        S_TAIL
    } st_e;

    function automatic op_e decode_op(input ctl_t c);
        case ({c.blk, c.wrt, c.meras, c.erase})
            4'b0001: return OP_SEG;
            4'b0010: return OP_MASS;
            4'b0011: return OP_FULL;
            4'b0100: return OP_BYTE;
            4'b1100: return OP_BLOCK;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fseq_tick_gen.sv
module fseq_tick_gen
    import flash_seq_pkg::*;
#(
    parameter int STALL_LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             src_a,
    input  logic             src_m,
    input  logic             src_s,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             stall
);
    localparam int STALL_W = $clog2(STALL_LIMIT + 1);

    logic             src_pick;
    logic             smp_d1, smp_d2;
    logic             rise;
    logic [DIV_W-1:0] div_cnt;
    logic [STALL_W-1:0] idle_cnt;

    always_comb begin
        case (sel)
            2'b00:   src_pick = src_a;
            2'b01:   src_pick = src_m;
            default: src_pick = src_s;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_d1 <= 1'b0;
            smp_d2 <= 1'b0;
        end else begin
            smp_d1 <= src_pick;
            smp_d2 <= smp_d1;
        end
    end

    assign rise = smp_d1 & ~smp_d2;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt <= '0;
        end else if (rise) begin
            div_cnt <= (div_cnt == div) ? '0 : div_cnt + 1'b1;
        end
    end

    assign tick = run & rise & (div_cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || rise) begin
            idle_cnt <= '0;
        end else if (!stall) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign stall = (idle_cnt == STALL_W'(STALL_LIMIT));

endmodule

// File: rtl/fseq_ctl_reg.sv
module fseq_ctl_reg
    import flash_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic emex,
    input  logic we,
    input  ctl_t wdata,
    output ctl_t q
);
    always_ff @(posedge clk) begin
        if (rst || emex) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/fseq_fsm.sv
module fseq_fsm
    import flash_seq_pkg::*;
#(
    parameter int ERASE_TICKS = 5000,
    parameter int WORD_TICKS  = 33,
    parameter int ELEM_TICKS  = 20,
    parameter int TAIL_TICKS  = 15,
    parameter int CNT_W       = 13
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  logic lock,
    input  logic arr_we,
    input  logic emex,
    input  logic tick,
    input  logic stall,
    output logic run,
    output logic busy,
    output logic elem_ready,
    output logic done,
    output logic fail,
    output op_e  op_mode
);
    st_e              st;
    op_e              op;
    op_e              req_op;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             done_q, fail_q;

    assign accept = arr_we & ~lock;
    assign req_op = decode_op(ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            op     <= OP_NONE;
            cnt    <= '0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (emex) begin
                st <= S_IDLE;
                op <= OP_NONE;
            end else if (st != S_IDLE && stall) begin
                st     <= S_IDLE;
                op     <= OP_NONE;
                fail_q <= 1'b1;
            end else begin
                case (st)
                    S_IDLE: begin
                        if (accept && req_op != OP_NONE) begin
                            op     <= req_op;
                            fail_q <= 1'b0;
                            if (req_op == OP_BLOCK) begin
                                st  <= S_ELEM;
                                cnt <= CNT_W'(ELEM_TICKS);
                            end else begin
                                st  <= S_RUN;
                                cnt <= (req_op == OP_BYTE) ? CNT_W'(WORD_TICKS)
                                                           : CNT_W'(ERASE_TICKS);
                            end
                        end
                    end
                    S_GAP: begin
                        if (accept) begin
                            st  <= S_ELEM;
                            cnt <= CNT_W'(ELEM_TICKS);
                        end else if (!(ctl.wrt && ctl.blk)) begin
                            st  <= S_TAIL;
                            cnt <= CNT_W'(TAIL_TICKS);
                        end
                    end
                    default: begin
                        if (tick) begin
                            if (cnt == CNT_W'(1)) begin
                                if (st == S_ELEM) begin
                                    st <= S_GAP;
                                end else begin
                                    st     <= S_IDLE;
                                    op     <= OP_NONE;
                                    done_q <= 1'b1;
                                end
                            end else begin
                                cnt <= cnt - 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    assign run        = (st != S_IDLE);
    assign busy       = run;
    assign elem_ready = (st == S_GAP);
    assign done       = done_q;
    assign fail       = fail_q;
    assign op_mode    = op;

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_seq_pkg::*;
#(
    parameter int ERASE_TICKS = 5000,
    parameter int WORD_TICKS  = 33,
    parameter int ELEM_TICKS  = 20,
    parameter int TAIL_TICKS  = 15,
    parameter int STALL_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       src_a,
    input  logic       src_m,
    input  logic       src_s,
    input  logic [1:0] clk_sel,
    input  logic [5:0] clk_div,
    input  logic       ctl_we,
    input  logic [3:0] ctl_wdata,
    output logic [3:0] ctl_q,
    input  logic       emex,
    input  logic       lock,
    input  logic       arr_we,
    output logic       busy,
    output logic       elem_ready,
    output logic       done,
    output logic       fail,
    output logic [2:0] op_mode
);
    localparam int MAX_TICKS = max2(max2(ERASE_TICKS, WORD_TICKS),
                                    max2(ELEM_TICKS, TAIL_TICKS));
    localparam int CNT_W = $clog2(MAX_TICKS + 1);

    ctl_t ctl_r;
    logic run, tick, stall;
    op_e  op_w;

    fseq_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .emex  (emex),
        .we    (ctl_we),
        .wdata (ctl_t'(ctl_wdata)),
        .q     (ctl_r)
    );

    fseq_tick_gen #(.STALL_LIMIT(STALL_LIMIT)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .src_a (src_a),
        .src_m (src_m),
        .src_s (src_s),
        .sel   (clk_sel),
        .div   (clk_div),
        .tick  (tick),
        .stall (stall)
    );

    fseq_fsm #(
        .ERASE_TICKS (ERASE_TICKS),
        .WORD_TICKS  (WORD_TICKS),
        .ELEM_TICKS  (ELEM_TICKS),
        .TAIL_TICKS  (TAIL_TICKS),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl_r),
        .lock       (lock),
        .arr_we     (arr_we),
        .emex       (emex),
        .tick       (tick),
        .stall      (stall),
        .run        (run),
        .busy       (busy),
        .elem_ready (elem_ready),
        .done       (done),
        .fail       (fail),
        .op_mode    (op_w)
    );

    assign ctl_q   = ctl_r;
    assign op_mode = op_w;

endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       emex,
    input logic       lock,
    input logic       arr_we,
    input logic       busy,
    input logic       elem_ready,
    input logic       done,
    input logic       fail,
    input logic [2:0] op_mode,
    input logic [3:0] ctl_q
);
    // R6: the element handshake only exists inside an operation
    p_ready_in_op_r6: assert property (@(posedge clk) disable iff (rst)
        elem_ready |-> busy);

    // R4: no operation code is shown while idle
    p_mode_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (op_mode == 3'd0));

    // R8: emergency exit empties the sequencer and the mode register
    p_emex_stop_r8: assert property (@(posedge clk) disable iff (rst)
        emex |=> (!busy && ctl_q == 4'd0 && !done));

    // R7: without an unlocked array write an idle sequencer stays idle
    p_no_trigger_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(arr_we && !lock)) |=> !busy);

    // R10: completion pulse follows a busy cycle and lasts one cycle
    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: raising the fail flag always coincides with the abort
    p_fail_abort_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> (!busy && $past(busy)));
endmodule

bind flash_op_seq flash_op_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .emex       (emex),
    .lock       (lock),
    .arr_we     (arr_we),
    .busy       (busy),
    .elem_ready (elem_ready),
    .done       (done),
    .fail       (fail),
    .op_mode    (op_mode),
    .ctl_q      (ctl_q)
);

// File: tb/flash_op_seq_tb_top.sv
module flash_op_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SRC_P      = 2;
    localparam int WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_a = 1'b0, src_m = 1'b0, src_s = 1'b0;
    logic [2:0] src_en = 3'b000;
    logic [1:0] clk_sel = 2'b00;
    logic [5:0] clk_div = 6'd0;
    logic       ctl_we = 1'b0;
    logic [3:0] ctl_wdata = 4'd0;
    logic [3:0] ctl_q;
    logic       emex = 1'b0;
    logic       lock = 1'b0;
    logic       arr_we = 1'b0;
    logic       busy, elem_ready, done, fail;
    logic [2:0] op_mode;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    int    lo_q[$];
    int    hi_q[$];
    int    kind_q[$];
    string tag_q[$];

    bit act, act_prev;
    int seg_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_op_seq dut_i (
        .clk(clk), .rst(rst), .src_a(src_a), .src_m(src_m), .src_s(src_s),
        .clk_sel(clk_sel), .clk_div(clk_div), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .emex(emex), .lock(lock),
        .arr_we(arr_we), .busy(busy), .elem_ready(elem_ready), .done(done),
        .fail(fail), .op_mode(op_mode)
    );

    always @(negedge clk) begin
        if (src_en[0]) src_a <= ~src_a;
        if (src_en[1]) src_m <= ~src_m;
        if (src_en[2]) src_s <= ~src_s;
    end

    task automatic chk(input bit ok, input string req, input int act_v,
                       input int lo, input int hi);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act_v, lo, hi);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG_LIMIT);
            finish_run();
        end
    end

    // monitor: measures each active (busy, not ready) segment and pops
    // kind 0 = normal end with done, 1 = end into elem_ready, 2 = abort
    always @(negedge clk) begin
        if (rst) begin
            act_prev = 1'b0;
            seg_len  = 0;
        end else begin
            act = busy && !elem_ready;
            if (act) seg_len = seg_len + 1;
            if (act_prev && !act) begin
                if (lo_q.size() == 0) begin
                    chk(1'b0, "scoreboard-empty", seg_len, 0, 0);
                end else begin
                    automatic int    lo = lo_q.pop_front();
                    automatic int    hi = hi_q.pop_front();
                    automatic int    kd = kind_q.pop_front();
                    automatic string tg = tag_q.pop_front();
                    if (kd == 2) begin
                        chk(!busy && !done, {tg, " abort-no-done"}, int'(done), 0, 0);
                    end else begin
                        chk(seg_len >= lo && seg_len <= hi, {tg, " length"}, seg_len, lo, hi);
                        if (kd == 0)
                            chk(!busy && done, {tg, " done-at-end"}, int'(done), 1, 1);
                        else
                            chk(busy && elem_ready, {tg, " ready-at-end"}, int'(elem_ready), 1, 1);
                    end
                end
                seg_len = 0;
            end
            act_prev = act;
        end
    end

    task automatic push_exp(input int ticks, input int div, input int kind,
                            input string tag);
        automatic int k = ticks * (div + 1);
        lo_q.push_back((k - 1) * SRC_P + 1);
        hi_q.push_back(k * SRC_P);
        kind_q.push_back(kind);
        tag_q.push_back(tag);
    endtask

    task automatic push_abort(input string tag);
        lo_q.push_back(0);
        hi_q.push_back(0);
        kind_q.push_back(2);
        tag_q.push_back(tag);
    endtask

    task automatic set_src(input logic [1:0] sel, input logic [5:0] div);
        @(negedge clk);
        clk_sel = sel;
        clk_div = div;
        src_en  = (sel == 2'b00) ? 3'b001 : (sel == 2'b01) ? 3'b010 : 3'b100;
    endtask

    task automatic write_ctl(input logic [3:0] v);
        @(negedge clk);
        ctl_we    = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic trig();
        @(negedge clk);
        arr_we = 1'b1;
        @(negedge clk);
        arr_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run_op(input logic [1:0] sel, input logic [5:0] div,
                          input logic [3:0] bits, input int ticks,
                          input int exp_mode, input string tag);
        set_src(sel, div);
        write_ctl(bits);
        push_exp(ticks, int'(div), 0, tag);
        trig();
        chk(busy && op_mode == 3'(exp_mode), {tag, " R4 op_mode"}, int'(op_mode),
            exp_mode, exp_mode);
        wait_idle();
        @(negedge clk);
        chk(!done && !fail, {tag, " R10 single done"}, int'(done), 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !elem_ready && !done && !fail, "R1 flags", int'(busy), 0, 0);
        chk(op_mode == 3'd0 && ctl_q == 4'd0, "R1 mode/ctl", int'(ctl_q), 0, 0);

        // R5 R2 segment erase from source A, divider 0
        run_op(2'b00, 6'd0, 4'b0001, 5000, 1, "R5 seg erase srcA");
        // R3 R2 byte write from source M, divide by 3
        run_op(2'b01, 6'd2, 4'b0100, 33, 4, "R3 byte srcM div3");
        // R2 both high select codes use source S
        run_op(2'b10, 6'd0, 4'b0100, 33, 4, "R2 byte sel10");
        // R3 maximum divider, sel 11
        run_op(2'b11, 6'd63, 4'b0100, 33, 4, "R3 byte sel11 div64");
        // R4 R5 mass and full erase
        run_op(2'b00, 6'd0, 4'b0010, 5000, 2, "R4 mass erase");
        run_op(2'b00, 6'd0, 4'b0011, 5000, 3, "R4 full erase");

        // R7 locked trigger ignored
        set_src(2'b00, 6'd0);
        write_ctl(4'b0100);
        lock = 1'b1;
        trig();
        repeat (3) @(negedge clk);
        chk(!busy && op_mode == 3'd0, "R7 locked trigger ignored", int'(busy), 0, 0);
        lock = 1'b0;

        // R7 unknown mode codes ignored
        write_ctl(4'b1000);
        trig();
        chk(!busy, "R7 code 1000 ignored", int'(busy), 0, 0);
        write_ctl(4'b0000);
        trig();
        chk(!busy, "R7 code 0000 ignored", int'(busy), 0, 0);

        // R7 array write during a byte write leaves its length unchanged
        write_ctl(4'b0100);
        push_exp(33, 0, 0, "R7 write during busy");
        trig();
        repeat (10) @(negedge clk);
        trig();
        chk(busy && op_mode == 3'd4, "R7 still byte write", int'(op_mode), 4, 4);
        wait_idle();

        // R6 block write: three elements, then clear the write bits
        write_ctl(4'b1100);
        for (int e = 0; e < 3; e++) push_exp(20, 0, 1, "R6 block element");
        push_exp(15, 0, 0, "R6 block overhead");
        trig();
        chk(op_mode == 3'd5 && !elem_ready, "R6 block mode", int'(op_mode), 5, 5);
        for (int e = 0; e < 2; e++) begin
            while (!elem_ready) @(negedge clk);
            trig();
            chk(busy && !elem_ready, "R6 element accepted", int'(elem_ready), 0, 0);
        end
        while (!elem_ready) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(busy && elem_ready, "R6 ready held while waiting", int'(elem_ready), 1, 1);
        write_ctl(4'b0000);
        wait_idle();

        // R8 emergency exit mid-erase
        write_ctl(4'b0001);
        push_abort("R8 emex");
        trig();
        repeat (100) @(negedge clk);
        emex = 1'b1;
        @(negedge clk);
        emex = 1'b0;
        chk(!busy && op_mode == 3'd0 && ctl_q == 4'd0, "R8 emex stop",
            int'(ctl_q), 0, 0);

        // R9 source stall aborts and sets fail
        set_src(2'b01, 6'd0);
        write_ctl(4'b0100);
        push_abort("R9 stall");
        trig();
        repeat (10) @(negedge clk);
        src_en = 3'b000;
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        chk(!busy && fail, "R9 stall abort", int'(fail), 1, 1);

        // R9 next accepted trigger clears fail
        src_en = 3'b010;
        push_exp(33, 0, 0, "R9 after stall");
        trig();
        chk(busy && !fail, "R9 fail cleared", int'(fail), 0, 0);
        wait_idle();
        repeat (3) @(negedge clk);
        chk(lo_q.size() == 0, "R10 scoreboard drained", lo_q.size(), 0, 0);

        finish_run();
    end
endmodule